// File: doc/BRIEF.md
# Video Input Timing Detector

This block watches a parallel video stream in the pixel clock domain and works out its raster timing. Its inputs are the horizontal sync, the vertical sync and the data-enable strobe. It reports:

- active width and height;
- the pulse length of each sync;
- horizontal porches in pixel clocks, and vertical porches in lines;
- the polarity of each sync, found from the signal itself;
- a link-status flag and a stream-present flag.

The block decides the polarity of each sync by comparing how long each level lasts. A sync that stops toggling reads back as "not available". Measurements gather in working counters while a frame is in progress. They are copied to the output registers only at the start of a vertical sync pulse, so software never sees a partial frame. A link-lock input and DE activity together qualify the stream-present flag. One port sets the timeout, in pixel clocks, that sync and DE inactivity are judged against.

Top module: `vtd_timing_detector`

## Requirements
- R1: After reset every measurement output is 0, `link_status` and `stream_present` are 0, and both polarity outputs read 2.
- R2: `hsync_pol` reads 0 when the low level of the horizontal sync lasts less than the high level (active low), and 1 when the high level is shorter or equal (active high). The measurements do not depend on the polarity.
- R3: `vsync_pol` follows the same rule and the same codes (0 active low, 1 active high) for the vertical sync.
- R4: A sync whose level stays unchanged for `quiet_limit` consecutive pixel clocks reads polarity code 2 (not available).
- R5: `act_width` is the number of DE-high pixels in an active line. `act_height` is the number of lines in the frame that hold at least one DE-high pixel.
- R6: `hsync_len` and `vsync_len` give the length of the active sync pulse in pixel clocks.
- R7: `hporch_back` counts pixel clocks from the end of the horizontal sync pulse to the first DE-high pixel. `hporch_front` counts pixel clocks from the last DE-high pixel to the start of the next horizontal sync pulse.
- R8: `vporch_back` counts lines without DE that lie between the end of the vertical sync pulse and the first active line. `vporch_front` counts lines without DE that lie between the last active line and the next vertical sync pulse.
- R9: Results update only at the start of a vertical sync pulse, and only when a previous start has been seen. Between such events, and whenever the vertical sync is absent, the outputs hold their values.
- R10: `link_status` equals `link_lock` delayed by one pixel clock. It reads 1 even when no video is active.
- R11: `stream_present` is 1 one clock after both of these hold: `link_lock` is high, and DE changed level within the last `quiet_limit` pixel clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_lock | input | 1 | Deserializer link locked |
| hsync_in | input | 1 | Horizontal sync, either polarity |
| vsync_in | input | 1 | Vertical sync, either polarity |
| de_in | input | 1 | Data enable, active high |
| quiet_limit | input | CNT_W | Inactivity timeout in pixel clocks |
| link_status | output | 1 | 1 locked, 0 unlocked |
| stream_present | output | 1 | 1 stream detected |
| hsync_pol | output | 2 | 0 active low, 1 active high, 2 not available |
| vsync_pol | output | 2 | 0 active low, 1 active high, 2 not available |
| act_width | output | CNT_W | Active pixels per line |
| act_height | output | LINE_W | Active lines per frame |
| hsync_len | output | CNT_W | Horizontal sync pulse, pixel clocks |
| vsync_len | output | CNT_W | Vertical sync pulse, pixel clocks |
| hporch_back | output | CNT_W | Horizontal back porch, pixel clocks |
| hporch_front | output | CNT_W | Horizontal front porch, pixel clocks |
| vporch_back | output | LINE_W | Vertical back porch, lines |
| vporch_front | output | LINE_W | Vertical front porch, lines |

## Verification
A wrong polarity decision turns every edge around, so the pulse lengths and porches come out swapped. That error shows in the first publication after the polarity settles, which is within two frames. A counter that fails to clear at a line or frame edge keeps growing, so the value published at the next vertical sync start is too large. A stuck activity or lock register shows on the flags one clock after the input changes, or once `quiet_limit` pixel clocks have passed. Running all four polarity combinations over two raster shapes exposes any asymmetry between the sync paths.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

    // Polarity report codes; software decodes these values.
    typedef enum logic [1:0] {
        POL_LOW  = 2'd0,
        POL_HIGH = 2'd1,
        POL_NONE = 2'd2
    } sync_pol_e;

    localparam int SYNC_COUNT = 2;
    localparam int SYNC_H     = 0;
    localparam int SYNC_V     = 1;

endpackage

// File: rtl/vtd_sync_classifier.sv
// Learns which level of a sync line is the pulse, from run lengths,
// and presents the line normalised to active-high.
module vtd_sync_classifier #(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_raw,
    input  logic [CNT_W-1:0]    quiet_limit,
    output logic                sync_act,
    output vtd_pkg::sync_pol_e  pol
);
    import vtd_pkg::*;

    localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             primed;
        logic             prev;
        logic             seen_edge;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] hi_len;
        logic [CNT_W-1:0] lo_len;
        logic             have_hi;
        logic             have_lo;
        sync_pol_e        pol;
    } cls_st_t;

    cls_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.prev   = sync_raw;
        if (!st_q.primed) begin
            st_d.run = C_ONE;
        end else if (sync_raw != st_q.prev) begin
            // a level just ended; keep its length only if it began at an edge
            if (st_q.seen_edge) begin
                if (st_q.prev) begin
                    st_d.hi_len  = st_q.run;
                    st_d.have_hi = 1'b1;
                end else begin
                    st_d.lo_len  = st_q.run;
                    st_d.have_lo = 1'b1;
                end
            end
            st_d.seen_edge = 1'b1;
            st_d.run       = C_ONE;
        end else begin
            if (st_q.run != '1) st_d.run = st_q.run + C_ONE;
            if (st_d.run >= quiet_limit) begin
                st_d.have_hi   = 1'b0;
                st_d.have_lo   = 1'b0;
                st_d.seen_edge = 1'b0;
            end
        end
        if (st_d.have_hi && st_d.have_lo)
            st_d.pol = (st_d.hi_len <= st_d.lo_len) ? POL_HIGH : POL_LOW;
        else
            st_d.pol = POL_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pol <= POL_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.pol)
            POL_HIGH: sync_act = sync_raw;
            POL_LOW:  sync_act = ~sync_raw;
            default:  sync_act = 1'b0;
        endcase
    end

    assign pol = st_q.pol;

endmodule

// File: rtl/vtd_de_monitor.sv
// Tracks whether DE has changed level within the timeout window.
module vtd_de_monitor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_in,
    input  logic [CNT_W-1:0] quiet_limit,
    output logic             de_alive
);
    localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             primed;
        logic             prev;
        logic [CNT_W-1:0] quiet;
        logic             alive;
    } mon_st_t;

    mon_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.prev   = de_in;
        if (st_q.primed && (de_in != st_q.prev)) begin
            st_d.quiet = '0;
            st_d.alive = 1'b1;
        end else begin
            if (st_q.quiet != '1) st_d.quiet = st_q.quiet + C_ONE;
            if (st_d.quiet >= quiet_limit) st_d.alive = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign de_alive = st_q.alive;

endmodule

// File: rtl/vtd_frame_meter.sv
// Per-line and per-frame counters on normalised syncs; publishes at frame start.
module vtd_frame_meter #(
    parameter int CNT_W  = 16,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_act,
    input  logic              vs_act,
    input  logic              de_in,
    output logic              frame_tick,
    output logic [CNT_W-1:0]  pub_width,
    output logic [LINE_W-1:0] pub_height,
    output logic [CNT_W-1:0]  pub_hsw,
    output logic [CNT_W-1:0]  pub_vsw,
    output logic [CNT_W-1:0]  pub_hbp,
    output logic [CNT_W-1:0]  pub_hfp,
    output logic [LINE_W-1:0] pub_vbp,
    output logic [LINE_W-1:0] pub_vfp
);
    localparam logic [CNT_W-1:0]  C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [LINE_W-1:0] L_ONE = {{(LINE_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              hs_prev;
        logic              vs_prev;
        logic              armed;
        logic              line_de;
        logic              seen_active;
        logic [CNT_W-1:0]  de_cnt;
        logic [CNT_W-1:0]  hbp_cnt;
        logic [CNT_W-1:0]  hfp_cnt;
        logic [CNT_W-1:0]  hs_cnt;
        logic [CNT_W-1:0]  vs_cnt;
        logic [CNT_W-1:0]  line_width;
        logic [CNT_W-1:0]  line_hbp;
        logic [CNT_W-1:0]  line_hfp;
        logic [CNT_W-1:0]  line_hsw;
        logic [CNT_W-1:0]  line_vsw;
        logic [LINE_W-1:0] height_run;
        logic [LINE_W-1:0] vbp_run;
        logic [LINE_W-1:0] vfp_run;
        logic [CNT_W-1:0]  out_width;
        logic [CNT_W-1:0]  out_hsw;
        logic [CNT_W-1:0]  out_vsw;
        logic [CNT_W-1:0]  out_hbp;
        logic [CNT_W-1:0]  out_hfp;
        logic [LINE_W-1:0] out_height;
        logic [LINE_W-1:0] out_vbp;
        logic [LINE_W-1:0] out_vfp;
    } mtr_st_t;

    mtr_st_t st_d, st_q;
    logic h_rise, h_fall, v_rise, v_fall;

    function automatic logic [CNT_W-1:0] inc_c(input logic [CNT_W-1:0] v);
        return (v == '1) ? v : v + C_ONE;
    endfunction

    function automatic logic [LINE_W-1:0] inc_l(input logic [LINE_W-1:0] v);
        return (v == '1) ? v : v + L_ONE;
    endfunction

    assign h_rise     = hs_act & ~st_q.hs_prev;
    assign h_fall     = ~hs_act & st_q.hs_prev;
    assign v_rise     = vs_act & ~st_q.vs_prev;
    assign v_fall     = ~vs_act & st_q.vs_prev;
    assign frame_tick = v_rise & st_q.armed;

    always_comb begin
        st_d         = st_q;
        st_d.hs_prev = hs_act;
        st_d.vs_prev = vs_act;

        // free-running pixel counters
        st_d.hfp_cnt = de_in ? '0 : inc_c(st_q.hfp_cnt);
        if (de_in) st_d.de_cnt = inc_c(st_q.de_cnt);
        if (de_in && !st_q.line_de) begin
            st_d.line_hbp = st_q.hbp_cnt;
            st_d.line_de  = 1'b1;
        end
        if (!hs_act && !st_q.line_de && !de_in) st_d.hbp_cnt = inc_c(st_q.hbp_cnt);
        if (hs_act) st_d.hs_cnt = inc_c(st_q.hs_cnt);
        if (h_fall) st_d.line_hsw = st_q.hs_cnt;
        if (vs_act) st_d.vs_cnt = inc_c(st_q.vs_cnt);
        if (v_fall) st_d.line_vsw = st_q.vs_cnt;

        // a line closes at each horizontal sync start
        if (h_rise) begin
            if (st_q.line_de) begin
                st_d.line_width  = st_q.de_cnt;
                st_d.line_hfp    = st_q.hfp_cnt;
                st_d.height_run  = inc_l(st_q.height_run);
                st_d.vfp_run     = '0;
                st_d.seen_active = 1'b1;
            end else begin
                st_d.vfp_run = inc_l(st_q.vfp_run);
                if (!st_q.seen_active) st_d.vbp_run = inc_l(st_q.vbp_run);
            end
            st_d.line_de = de_in;
            st_d.de_cnt  = de_in ? C_ONE : '0;
            st_d.hbp_cnt = '0;
            st_d.hs_cnt  = C_ONE;
        end

        // back porch counting restarts when the vertical pulse ends
        if (v_fall) begin
            st_d.vbp_run     = '0;
            st_d.seen_active = 1'b0;
        end

        // frame boundary: publish the finished frame
        if (v_rise) begin
            if (st_q.armed) begin
                st_d.out_width  = st_d.line_width;
                st_d.out_hsw    = st_d.line_hsw;
                st_d.out_vsw    = st_d.line_vsw;
                st_d.out_hbp    = st_d.line_hbp;
                st_d.out_hfp    = st_d.line_hfp;
                st_d.out_height = st_d.height_run;
                st_d.out_vbp    = st_d.vbp_run;
                st_d.out_vfp    = st_d.vfp_run;
            end
            st_d.armed      = 1'b1;
            st_d.height_run = '0;
            st_d.vs_cnt     = C_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pub_width  = st_q.out_width;
    assign pub_height = st_q.out_height;
    assign pub_hsw    = st_q.out_hsw;
    assign pub_vsw    = st_q.out_vsw;
    assign pub_hbp    = st_q.out_hbp;
    assign pub_hfp    = st_q.out_hfp;
    assign pub_vbp    = st_q.out_vbp;
    assign pub_vfp    = st_q.out_vfp;

endmodule

// File: rtl/vtd_timing_detector.sv
module vtd_timing_detector #(
    parameter int CNT_W  = 16,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_lock,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              de_in,
    input  logic [CNT_W-1:0]  quiet_limit,
    output logic              link_status,
    output logic              stream_present,
    output logic [1:0]        hsync_pol,
    output logic [1:0]        vsync_pol,
    output logic [CNT_W-1:0]  act_width,
    output logic [LINE_W-1:0] act_height,
    output logic [CNT_W-1:0]  hsync_len,
    output logic [CNT_W-1:0]  vsync_len,
    output logic [CNT_W-1:0]  hporch_back,
    output logic [CNT_W-1:0]  hporch_front,
    output logic [LINE_W-1:0] vporch_back,
    output logic [LINE_W-1:0] vporch_front
);
    import vtd_pkg::*;

    logic [SYNC_COUNT-1:0] sync_raw;
    logic [SYNC_COUNT-1:0] sync_act;
    sync_pol_e             sync_pol [SYNC_COUNT];
    logic                  de_alive;
    logic                  frame_tick;

    assign sync_raw[SYNC_H] = hsync_in;
    assign sync_raw[SYNC_V] = vsync_in;

    for (genvar gi = 0; gi < SYNC_COUNT; gi++) begin : g_sync
        vtd_sync_classifier #(.CNT_W(CNT_W)) u_cls (
            .clk         (clk),
            .rst_n       (rst_n),
            .sync_raw    (sync_raw[gi]),
            .quiet_limit (quiet_limit),
            .sync_act    (sync_act[gi]),
            .pol         (sync_pol[gi])
        );
    end

    vtd_de_monitor #(.CNT_W(CNT_W)) u_de (
        .clk         (clk),
        .rst_n       (rst_n),
        .de_in       (de_in),
        .quiet_limit (quiet_limit),
        .de_alive    (de_alive)
    );

    vtd_frame_meter #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_act     (sync_act[SYNC_H]),
        .vs_act     (sync_act[SYNC_V]),
        .de_in      (de_in),
        .frame_tick (frame_tick),
        .pub_width  (act_width),
        .pub_height (act_height),
        .pub_hsw    (hsync_len),
        .pub_vsw    (vsync_len),
        .pub_hbp    (hporch_back),
        .pub_hfp    (hporch_front),
        .pub_vbp    (vporch_back),
        .pub_vfp    (vporch_front)
    );

    typedef struct packed {
        logic link;
        logic stream;
    } flag_st_t;

    flag_st_t fl_d, fl_q;

    always_comb begin
        fl_d.link   = link_lock;
        fl_d.stream = link_lock & de_alive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign link_status    = fl_q.link;
    assign stream_present = fl_q.stream;
    assign hsync_pol      = sync_pol[SYNC_H];
    assign vsync_pol      = sync_pol[SYNC_V];

endmodule

// File: rtl/vtd_timing_detector_chk.sv
module vtd_timing_detector_chk #(
    parameter int CNT_W  = 16,
    parameter int LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_lock,
    input logic              link_status,
    input logic              stream_present,
    input logic [1:0]        hsync_pol,
    input logic [1:0]        vsync_pol,
    input logic [CNT_W-1:0]  act_width,
    input logic [LINE_W-1:0] act_height,
    input logic              frame_tick
);
    AST_HPOL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) hsync_pol != 2'd3); // R2
    AST_VPOL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) vsync_pol != 2'd3); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_tick |=> ($stable(act_width) && $stable(act_height))); // R9
    AST_LINK_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(link_lock) |=> link_status); // R10
    AST_LINK_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(link_lock) |=> !link_status); // R10
    AST_STREAM_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n) !link_lock |=> !stream_present); // R11
endmodule

bind vtd_timing_detector vtd_timing_detector_chk #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .link_lock      (link_lock),
    .link_status    (link_status),
    .stream_present (stream_present),
    .hsync_pol      (hsync_pol),
    .vsync_pol      (vsync_pol),
    .act_width      (act_width),
    .act_height     (act_height),
    .frame_tick     (frame_tick)
);

// File: tb/tb_vtd_timing_detector.sv
`timescale 1ns/1ps
module tb_vtd_timing_detector;
    localparam int CNT_W  = 16;
    localparam int LINE_W = 12;
    localparam int LIMIT  = 1000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              link_lock = 1'b0;
    logic              hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
    logic [CNT_W-1:0]  quiet_limit = CNT_W'(LIMIT);
    logic              link_status, stream_present;
    logic [1:0]        hsync_pol, vsync_pol;
    logic [CNT_W-1:0]  act_width, hsync_len, vsync_len, hporch_back, hporch_front;
    logic [LINE_W-1:0] act_height, vporch_back, vporch_front;

    vtd_timing_detector #(.CNT_W(CNT_W), .LINE_W(LINE_W)) dut (.*);

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic h, input logic v, input logic d);
        @(negedge clk);
        hsync_in = h;
        vsync_in = v;
        de_in    = d;
    endtask

    task automatic idle(input int n, input bit hp, input bit vp);
        for (int i = 0; i < n; i++) drive(~hp, ~vp, 1'b0);
    endtask

    task automatic do_reset(input bit hp, input bit vp);
        rst_n = 1'b0;
        idle(5, hp, vp);
        rst_n = 1'b1;
        idle(4, hp, vp);
    endtask

    task automatic run_frames(input int hsw, input int hbp, input int w, input int hfp,
                              input int vsw, input int vbp, input int h, input int vfp,
                              input bit hp, input bit vp, input int nf);
        int lt, lines;
        lt    = hsw + hbp + w + hfp;
        lines = vsw + vbp + h + vfp;
        for (int f = 0; f < nf; f++)
            for (int l = 0; l < lines; l++)
                for (int c = 0; c < lt; c++) begin
                    bit ah, av, ad;
                    ah = (c < hsw);
                    av = (l < vsw);
                    ad = (l >= vsw + vbp) && (l < vsw + vbp + h) &&
                         (c >= hsw + hbp) && (c < hsw + hbp + w);
                    drive(hp ? ah : ~ah, vp ? av : ~av, ad);
                end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
    end

    initial begin
        int cfg [2][8];
        logic [CNT_W-1:0]  held_w;
        logic [LINE_W-1:0] held_h;
        // hsw hbp w hfp vsw vbp h vfp
        cfg[0] = '{3, 4, 10, 5, 2, 3, 6, 2};
        cfg[1] = '{2, 3, 7, 4, 1, 2, 5, 3};

        // R1: reset state
        do_reset(1'b1, 1'b1);
        check("R1 width", act_width, 0);
        check("R1 height", act_height, 0);
        check("R1 hsync_len", hsync_len, 0);
        check("R1 vsync_len", vsync_len, 0);
        check("R1 hporch_back", hporch_back, 0);
        check("R1 hporch_front", hporch_front, 0);
        check("R1 vporch_back", vporch_back, 0);
        check("R1 vporch_front", vporch_front, 0);
        check("R1 hsync_pol", hsync_pol, 2);
        check("R1 vsync_pol", vsync_pol, 2);
        check("R1 link_status", link_status, 0);
        check("R1 stream_present", stream_present, 0);

        // R10: locked link without video reads locked; R11: no stream
        link_lock = 1'b1;
        idle(2, 1'b1, 1'b1);
        check("R10 locked without stream", link_status, 1);
        check("R11 no DE activity", stream_present, 0);

        // sweep: two raster shapes x four polarity combinations
        for (int k = 0; k < 2; k++)
            for (int pc = 0; pc < 4; pc++) begin
                bit hp, vp;
                int lt;
                hp = pc[0];
                vp = pc[1];
                lt = cfg[k][0] + cfg[k][1] + cfg[k][2] + cfg[k][3];
                do_reset(hp, vp);
                run_frames(cfg[k][0], cfg[k][1], cfg[k][2], cfg[k][3],
                           cfg[k][4], cfg[k][5], cfg[k][6], cfg[k][7], hp, vp, 6);
                check("R2 hsync polarity", hsync_pol, {1'b0, hp});
                check("R3 vsync polarity", vsync_pol, {1'b0, vp});
                check("R5 width", act_width, cfg[k][2]);
                check("R5 height", act_height, cfg[k][6]);
                check("R6 hsync length", hsync_len, cfg[k][0]);
                check("R6 vsync length", vsync_len, cfg[k][4] * lt);
                check("R7 h back porch", hporch_back, cfg[k][1]);
                check("R7 h front porch", hporch_front, cfg[k][3]);
                check("R8 v back porch", vporch_back, cfg[k][5]);
                check("R8 v front porch", vporch_front, cfg[k][7]);
                check("R11 stream present", stream_present, 1);
            end

        // last run: shape 1, both active high. DE timeout and sync loss.
        held_w = act_width;
        held_h = act_height;
        idle(900, 1'b1, 1'b1);
        check("R11 DE within timeout", stream_present, 1);
        idle(250, 1'b1, 1'b1);
        check("R11 DE timed out", stream_present, 0);
        check("R10 still locked", link_status, 1);
        check("R4 hsync absent", hsync_pol, 2);
        check("R4 vsync absent", vsync_pol, 2);
        check("R9 width held", act_width, held_w);
        check("R9 height held", act_height, held_h);

        // vertical sync never asserted: nothing is published
        do_reset(1'b1, 1'b1);
        run_frames(3, 4, 10, 5, 0, 3, 6, 2, 1'b1, 1'b1, 4);
        check("R4 vsync never toggles", vsync_pol, 2);
        check("R2 hsync still classified", hsync_pol, 1);
        check("R9 no publication width", act_width, 0);
        check("R9 no publication height", act_height, 0);

        // link drop while DE is active
        link_lock = 1'b0;
        idle(2, 1'b1, 1'b1);
        check("R10 unlocked", link_status, 0);
        check("R11 needs link", stream_present, 0);
        link_lock = 1'b1;
        idle(2, 1'b1, 1'b1);
        check("R10 relocked", link_status, 1);
        check("R11 stream back", stream_present, 1);

        report();
    end
endmodule